// File: doc/BRIEF.md
# Suspect Resource Intersection Isolator

This block finds the one faulty logic resource in a device by comparing pairs of competing configurations. Each configuration is described by a usage mask with one bit per resource. The two configurations in a pairing use disjoint resources and run side by side. An external comparator says whether their outputs agreed. The block keeps a vector of suspect resources. Each comparison that disagrees intersects the suspect vector with the resources the two configurations used. Once exactly one suspect is left, the block reports that resource's index and how many pairings it took.

A mode input chooses between two fault-exposure assumptions. In the always-exposing mode, a pairing whose outputs agree proves that every resource it used is healthy. Before the first disagreement, those resources are remembered as healthy. After it, they are removed from the suspect vector. In the intermittent mode, an agreeing pairing proves nothing and changes no state except the pairing count. The design assumes a single stuck-at fault confined to one resource. If a trial would leave no suspect at all, the previous set is kept and a sticky inconsistency flag is raised.

The controller has three states. ST_IDLE means no disagreement has been seen yet. ST_NARROW means a suspect set exists with more than one member. ST_ISOLATED means a single suspect remains.

The transitions are:
- ST_IDLE to ST_NARROW: the first disagreement leaves more than one suspect.
- ST_IDLE to ST_ISOLATED: the first disagreement leaves exactly one suspect.
- ST_NARROW to ST_ISOLATED: any update leaves exactly one suspect.
- Any state to ST_IDLE: synchronous clear.

Top module: `suspect_isolator`

## Requirements
- R1: After reset or a synchronous clear (`clr` high at a clock edge), all of the following hold: the block is idle, `done` is low, `suspects` is all zero, `pair_count` is zero and `inconsistent` is low.
- R2: A trial is accepted when `trial_valid` is high, the block is not isolated and `clr` is low. Each accepted trial adds one to `pair_count`, which stops at 2^CNT_W-1 and does not wrap.
- R3: The `agree` input is 1 when the two outputs matched and 0 on a disagreement. In always-exposing mode (`intermittent` = 0), an agreeing trial while idle marks every resource in `mask_a | mask_b` as healthy. While narrowing, the same trial clears those bits from `suspects`.
- R4: The first disagreeing trial loads `suspects` with `(mask_a | mask_b)` minus the resources already marked healthy, and leaves the idle state.
- R5: Each later disagreeing trial replaces `suspects` with `suspects & (mask_a | mask_b)`.
- R6: In intermittent mode (`intermittent` = 1), an agreeing trial leaves `suspects` unchanged and marks nothing healthy.
- R7: A trial whose result would be an empty suspect set leaves `suspects` unchanged and sets `inconsistent`. The flag stays high until a clear.
- R8: When exactly one suspect bit remains, `done` goes high and `fault_idx` gives that bit's position, with bit 0 as index 0.
- R9: While `done` is high, trials are ignored: `suspects`, `pair_count` and `fault_idx` hold.
- R10: A cycle with `trial_valid` low changes no output, whatever the masks and `agree` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear back to idle |
| trial_valid | input | 1 | Strobe offering one pairing result |
| intermittent | input | 1 | 1: agreeing trials carry no information |
| agree | input | 1 | Comparator result, 1 = outputs matched |
| mask_a | input | NUM_RES | Resources used by the first configuration |
| mask_b | input | NUM_RES | Resources used by the second configuration |
| suspects | output | NUM_RES | Current suspect vector |
| done | output | 1 | Exactly one suspect remains |
| fault_idx | output | $clog2(NUM_RES) | Index of the lowest set suspect bit |
| pair_count | output | CNT_W | Accepted pairings, saturating |
| inconsistent | output | 1 | A trial would have emptied the suspect set |

## Verification
The bench builds the block with NUM_RES = 16 and CNT_W = 4.

Sixteen resources make every mask easy to write out by hand, and they put the top index, 15, within reach. With a 4-bit counter, twenty accepted trials drive `pair_count` into saturation at 15, which checks that it holds instead of wrapping. The bench runs both modes with the same 16-bit masks. This contrasts healthy-marking before the first disagreement against no information at all, and it makes both the empty-intersection case and direct isolation on the first disagreement reachable in a few trials.

// File: rtl/iso_pkg.sv
package iso_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_NARROW   = 2'd1,
        ST_ISOLATED = 2'd2
    } iso_state_e;
endpackage

// File: rtl/iso_popcount.sv
module iso_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/iso_lowest_idx.sv
module iso_lowest_idx #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/iso_sat_counter.sv
module iso_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   count <= '0;
        else if (clr)                 count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R2
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count == MAXV) |=> count == MAXV);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count != MAXV) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/suspect_isolator.sv
module suspect_isolator #(
    parameter int NUM_RES = 16,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       trial_valid,
    input  logic                       intermittent,
    input  logic                       agree,
    input  logic [NUM_RES-1:0]         mask_a,
    input  logic [NUM_RES-1:0]         mask_b,
    output logic [NUM_RES-1:0]         suspects,
    output logic                       done,
    output logic [$clog2(NUM_RES)-1:0] fault_idx,
    output logic [CNT_W-1:0]           pair_count,
    output logic                       inconsistent
);
    import iso_pkg::*;

    localparam int IW = $clog2(NUM_RES);
    localparam int PW = $clog2(NUM_RES + 1);

    iso_state_e         state_q, state_d;
    logic [NUM_RES-1:0] susp_q, susp_d;
    logic [NUM_RES-1:0] healthy_q, healthy_d;
    logic [NUM_RES-1:0] cand;
    logic               incon_q, incon_d;
    logic               accept;
    logic               update;
    logic [NUM_RES-1:0] used;
    logic [PW-1:0]      cand_cnt;
    logic [IW-1:0]      low_idx;

    assign used   = mask_a | mask_b;
    assign accept = trial_valid && !clr && (state_q != ST_ISOLATED);

    iso_popcount #(.N(NUM_RES), .CW(PW)) u_pop (
        .vec   (cand),
        .count (cand_cnt)
    );

    iso_lowest_idx #(.N(NUM_RES), .IW(IW)) u_enc (
        .vec (susp_q),
        .idx (low_idx)
    );

    iso_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (accept),
        .count (pair_count)
    );

    // Candidate suspect set and whether this trial writes it.
    always_comb begin
        cand   = susp_q;
        update = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !agree) begin
                    cand   = used & ~healthy_q;
                    update = 1'b1;
                end
            end
            ST_NARROW: begin
                if (accept && !agree) begin
                    cand   = susp_q & used;
                    update = 1'b1;
                end else if (accept && !intermittent) begin
                    cand   = susp_q & ~used;
                    update = 1'b1;
                end
            end
            ST_ISOLATED: begin
                cand   = susp_q;
                update = 1'b0;
            end
            default: begin
                cand   = susp_q;
                update = 1'b0;
            end
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d   = state_q;
        susp_d    = susp_q;
        healthy_d = healthy_q;
        incon_d   = incon_q;
        if (accept && agree && !intermittent && state_q == ST_IDLE) begin
            healthy_d = healthy_q | used;
        end
        if (update) begin
            if (cand_cnt == '0) begin
                incon_d = 1'b1;
            end else begin
                susp_d  = cand;
                state_d = (cand_cnt == PW'(1)) ? ST_ISOLATED : ST_NARROW;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            susp_q    <= '0;
            healthy_q <= '0;
            incon_q   <= 1'b0;
        end else if (clr) begin
            state_q   <= ST_IDLE;
            susp_q    <= '0;
            healthy_q <= '0;
            incon_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            susp_q    <= susp_d;
            healthy_q <= healthy_d;
            incon_q   <= incon_d;
        end
    end

    // Outputs.
    always_comb begin
        suspects     = susp_q;
        done         = (state_q == ST_ISOLATED);
        fault_idx    = low_idx;
        inconsistent = incon_q;
    end

    // R8
    isolated_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISOLATED) |-> ($countones(susp_q) == 1));

    // R9
    isolated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISOLATED && !clr) |=> ($stable(susp_q) && state_q == ST_ISOLATED));

    // R5
    narrow_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NARROW && !clr) |=> ((susp_q & ~$past(susp_q)) == '0));

    // R6
    intermittent_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_valid && agree && intermittent && !clr) |=> $stable(susp_q));

    // R1
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_IDLE && susp_q == '0 && !incon_q));

    // R7
    incon_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (incon_q && !clr) |=> incon_q);

    // R10
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trial_valid && !clr) |=> ($stable(susp_q) && $stable(incon_q)));
endmodule

// File: tb/sim_suspect_isolator.sv
module sim_suspect_isolator;
    localparam int N  = 16;
    localparam int CW = 4;
    localparam int IW = $clog2(N);

    typedef struct {
        logic [N-1:0]  susp;
        logic          done;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          incon;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          trial_valid = 1'b0;
    logic          intermittent = 1'b0;
    logic          agree = 1'b1;
    logic [N-1:0]  mask_a = '0;
    logic [N-1:0]  mask_b = '0;
    logic [N-1:0]  suspects;
    logic          done;
    logic [IW-1:0] fault_idx;
    logic [CW-1:0] pair_count;
    logic          inconsistent;

    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    suspect_isolator #(.NUM_RES(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .trial_valid(trial_valid),
        .intermittent(intermittent), .agree(agree), .mask_a(mask_a), .mask_b(mask_b),
        .suspects(suspects), .done(done), .fault_idx(fault_idx),
        .pair_count(pair_count), .inconsistent(inconsistent)
    );

    // Monitor: compare one expected item each half-cycle after the edge that produced it.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (suspects !== e.susp || done !== e.done || pair_count !== e.cnt ||
                inconsistent !== e.incon || (e.done && fault_idx !== e.idx)) begin
                errors++;
                $display("FAIL %s: got susp=%h done=%b idx=%0d cnt=%0d incon=%b, expected susp=%h done=%b idx=%0d cnt=%0d incon=%b",
                         e.tag, suspects, done, fault_idx, pair_count, inconsistent,
                         e.susp, e.done, e.idx, e.cnt, e.incon);
            end
        end
    end

    task automatic drive(input logic v, input logic c, input logic im, input logic ag,
                         input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [N-1:0] es, input logic ed, input int ei,
                         input int ec, input logic ein, input string tag);
        exp_t e;
        @(negedge clk);
        trial_valid  = v;
        clr          = c;
        intermittent = im;
        agree        = ag;
        mask_a       = a;
        mask_b       = b;
        @(posedge clk);
        e.susp = es; e.done = ed; e.idx = IW'(ei); e.cnt = CW'(ec); e.incon = ein; e.tag = tag;
        exp_q.push_back(e);
        #1;
        trial_valid = 1'b0;
        clr         = 1'b0;
    endtask

    task automatic do_clear(input string tag);
        drive(0, 1, 0, 1, '0, '0, '0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (suspects !== '0 || done !== 1'b0 || pair_count !== '0 || inconsistent !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got susp=%h done=%b cnt=%0d incon=%b, expected 0 0 0 0",
                     suspects, done, pair_count, inconsistent);
        end
        rst_n = 1'b1;

        // Always-exposing mode narrowing (R3, R4, R5, R8).
        drive(1, 0, 0, 1, 16'h000F, 16'h00F0, 16'h0000, 0, 0, 1, 0, "R3 agree while idle");
        drive(0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'h0000, 0, 0, 1, 0, "R10 valid low");
        drive(1, 0, 0, 0, 16'h0F0F, 16'h3000, 16'h3F00, 0, 0, 2, 0, "R4 first discrepancy minus healthy");
        drive(1, 0, 0, 0, 16'h0300, 16'h1000, 16'h1300, 0, 0, 3, 0, "R5 intersection");
        drive(1, 0, 0, 1, 16'h0100, 16'h0200, 16'h1000, 1, 12, 4, 0, "R8 agree removes, isolated idx 12");
        drive(1, 0, 0, 0, 16'h0001, 16'h0000, 16'h1000, 1, 12, 4, 0, "R9 trial ignored when done");
        do_clear("R1 clear");

        // Intermittent mode (R6, R7).
        drive(1, 0, 1, 1, 16'hFFFF, 16'h0000, 16'h0000, 0, 0, 1, 0, "R6 agree idle no effect");
        drive(1, 0, 1, 0, 16'h00FF, 16'hFF00, 16'hFFFF, 0, 0, 2, 0, "R6 first discrepancy all used");
        drive(1, 0, 1, 1, 16'h0001, 16'h0000, 16'hFFFF, 0, 0, 3, 0, "R6 agree narrowing no effect");
        drive(1, 0, 1, 0, 16'h00F0, 16'h0000, 16'h00F0, 0, 0, 4, 0, "R5 intermittent intersect");
        drive(1, 0, 1, 0, 16'hF00F, 16'h0000, 16'h00F0, 0, 0, 5, 1, "R7 empty keeps set");
        drive(1, 0, 1, 0, 16'h0020, 16'h0000, 16'h0020, 1, 5, 6, 1, "R7 flag sticky, R8 idx 5");
        do_clear("R1 clear after flag");

        // Empty first discrepancy after healthy marking (R3, R7).
        drive(1, 0, 0, 1, 16'h00FF, 16'h0000, 16'h0000, 0, 0, 1, 0, "R3 mark healthy");
        drive(1, 0, 0, 0, 16'h0003, 16'h0000, 16'h0000, 0, 0, 2, 1, "R7 first discrepancy all healthy");
        do_clear("R1 clear");

        // Direct isolation on first discrepancy at top index (R8).
        drive(1, 0, 0, 0, 16'h0000, 16'h8000, 16'h8000, 1, 15, 1, 0, "R8 direct isolate idx 15");
        do_clear("R1 clear");

        // Saturation (R2).
        for (int i = 0; i < 20; i++) begin
            drive(1, 0, 1, 1, 16'h0001, 16'h0002, 16'h0000, 0, 0, (i + 1 > 15) ? 15 : i + 1, 0,
                  "R2 counter saturates");
        end

        @(negedge clk);
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule